// File: doc/BRIEF.md
# Clip Marker and Fail-Safe Output Sequencer

This block sits between the one-bit decision of a delta-sigma modulator and the output pins. On every rising edge of the modulator clock it registers one output bit. In normal operation that bit is the modulator decision. When the analog front end reports that the input has reached a clip level, the block drives a constant level instead of the stuck comparator stream. Once every 128 cycles it inserts one bit of the opposite value, so a receiver can still see that the converter is alive.

On a fault (loss of the high-side supply or a common-mode overvoltage), the block drives the data output to a steady logic 1 after a short pipeline delay. A further 256 cycles later it also parks the clock output at logic 1. A receiver can then tell a full-scale input, which keeps producing periodic markers, from a dead converter, which produces no edges at all. The clip and fault flags arrive as synchronous digital inputs and are sampled on the rising clock edge. Reset is synchronous and active low.

Top module: `clip_failsafe_seq`

## Requirements
- R1: While `clip_pos` is high and no fault is active, `data_out` is 1 on every cycle except that a single 0 appears once every 128 cycles; the values of `mod_bit` are ignored.
- R2: While `clip_neg` is high (and `clip_pos` low) and no fault is active, `data_out` is 0 on every cycle except that a single 1 appears once every 128 cycles; the values of `mod_bit` are ignored.
- R3: When `supply_lost` or `cm_over` is sampled high on edge k and stays high, `data_out` is 1 from edge k+1 onward.
- R4: During a sustained fault that starts being sampled on edge k, `clk_out` is released until edge k+256 and held at 1 from edge k+257 onward, which is 256 cycles after `data_out` went steady high.
- R5: With no clip and no fault flag, `data_out` after each rising edge equals the `mod_bit` sampled at that edge.
- R6: The 128-cycle marker count restarts whenever clipping begins or changes polarity, so the first marker appears on the 128th edge after the entry edge.
- R7: A fault takes priority over clipping: once `data_out` is forced high, no marker bit of either polarity appears.
- R8: On the first edge where all fault flags are sampled low, `data_out` returns to normal or clip behaviour and `clk_out` is released at that same edge; clipping that is still present counts as a fresh entry.
- R9: A fault flag that is high for only a single sampled edge has no effect on `data_out` or `clk_out`.
- R10: While `rst_n` is low at a rising edge, `data_out` becomes 0 and `clk_out` follows `clk`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Modulator clock; all flags are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mod_bit | input | 1 | Raw one-bit modulator decision |
| clip_pos | input | 1 | Input at or above the positive clip level |
| clip_neg | input | 1 | Input at or below the negative clip level |
| supply_lost | input | 1 | High-side supply missing |
| cm_over | input | 1 | Input common-mode voltage above the detection level |
| data_out | output | 1 | Registered output bit stream |
| clk_out | output | 1 | Modulator clock, parked at 1 during a long fault |

## Verification
Two functions collide when a fault's forcing edge falls on the same cycle as a clip marker. The bench holds the positive clip flag for 127 edges and raises the overvoltage flag just before the 128th edge, so the first forced-high cycle is exactly the cycle where the marker 0 is due. The scoreboard expects a 1 there and on every later cycle of the fault. It then expects the marker count to restart from the edge at which the fault clears. A second case starts the negative clip and a supply fault on the same edge and checks that no marker 1 breaks the high level over more than two marker periods.

// File: rtl/cfs_pkg.sv
package cfs_pkg;

    typedef enum logic [1:0] {
        CLIP_NONE = 2'd0,
        CLIP_HI   = 2'd1,
        CLIP_LO   = 2'd2
    } clip_kind_e;

endpackage

// File: rtl/cfs_marker_gen.sv
module cfs_marker_gen
    import cfs_pkg::*;
#(
    parameter int MARK_PERIOD = 128
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clip_pos,
    input  logic       clip_neg,
    input  logic       restart,
    output clip_kind_e kind,
    output logic       marker
);
    localparam int CW = $clog2(MARK_PERIOD);
    localparam logic [CW-1:0] LAST = CW'(MARK_PERIOD - 1);

    typedef struct packed {
        clip_kind_e    kind;
        logic [CW-1:0] cnt;
    } mark_state_t;

    mark_state_t st_d, st_q;
    logic        entry;

    always_comb begin
        kind = CLIP_NONE;
        if (clip_pos) begin
            kind = CLIP_HI;
        end else if (clip_neg) begin
            kind = CLIP_LO;
        end
        entry  = (kind != st_q.kind);
        marker = (kind != CLIP_NONE) && !entry && (st_q.cnt == LAST);

        st_d = st_q;
        if (restart) begin
            st_d.kind = CLIP_NONE;
            st_d.cnt  = '0;
        end else begin
            st_d.kind = kind;
            if (kind == CLIP_NONE || entry || marker) begin
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{kind: CLIP_NONE, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/cfs_fault_seq.sv
module cfs_fault_seq #(
    parameter int HOLD_CYCLES = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fault_now,
    output logic armed,
    output logic force_hi,
    output logic hold
);
    localparam int HW = $clog2(HOLD_CYCLES + 1);
    localparam logic [HW-1:0] HOLD_END = HW'(HOLD_CYCLES);

    typedef struct packed {
        logic          armed;
        logic [HW-1:0] cnt;
        logic          hold;
    } fault_state_t;

    fault_state_t st_d, st_q;

    always_comb begin
        force_hi = st_q.armed && fault_now;

        st_d       = st_q;
        st_d.armed = fault_now;
        if (!fault_now) begin
            st_d.cnt  = '0;
            st_d.hold = 1'b0;
        end else begin
            if (st_q.armed && (st_q.cnt != HOLD_END)) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
            st_d.hold = (st_q.cnt == HOLD_END);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{armed: 1'b0, cnt: '0, hold: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign armed = st_q.armed;
    assign hold  = st_q.hold;

endmodule

// File: rtl/clip_failsafe_seq.sv
module clip_failsafe_seq
    import cfs_pkg::*;
#(
    parameter int MARK_PERIOD = 128,
    parameter int HOLD_CYCLES = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mod_bit,
    input  logic clip_pos,
    input  logic clip_neg,
    input  logic supply_lost,
    input  logic cm_over,
    output logic data_out,
    output logic clk_out
);
    typedef struct packed {
        logic data;
    } out_state_t;

    out_state_t st_d, st_q;
    clip_kind_e kind_w;
    logic       marker_w;
    logic       fault_now;
    logic       armed_w;
    logic       force_w;
    logic       hold_w;

    assign fault_now = supply_lost | cm_over;

    cfs_fault_seq #(
        .HOLD_CYCLES(HOLD_CYCLES)
    ) u_fault (
        .clk      (clk),
        .rst_n    (rst_n),
        .fault_now(fault_now),
        .armed    (armed_w),
        .force_hi (force_w),
        .hold     (hold_w)
    );

    cfs_marker_gen #(
        .MARK_PERIOD(MARK_PERIOD)
    ) u_marker (
        .clk     (clk),
        .rst_n   (rst_n),
        .clip_pos(clip_pos),
        .clip_neg(clip_neg),
        .restart (force_w),
        .kind    (kind_w),
        .marker  (marker_w)
    );

    always_comb begin
        st_d = st_q;
        if (force_w) begin
            st_d.data = 1'b1;
        end else begin
            unique case (kind_w)
                CLIP_HI: st_d.data = ~marker_w;
                CLIP_LO: st_d.data = marker_w;
                default: st_d.data = mod_bit;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{data: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign data_out = st_q.data;
    assign clk_out  = clk | hold_w;

endmodule

// File: rtl/cfs_checker.sv
module cfs_checker (
    input logic clk,
    input logic rst_n,
    input logic mod_bit,
    input logic clip_pos,
    input logic clip_neg,
    input logic fault_now,
    input logic armed,
    input logic marker,
    input logic hold,
    input logic data_out
);
    AST_CLIP_HI_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        clip_pos && !fault_now && !marker |=> data_out); // R1

    AST_CLIP_LO_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        clip_neg && !clip_pos && !fault_now && !marker |=> !data_out); // R2

    AST_FAULT_FORCES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        armed && fault_now |=> data_out); // R3

    AST_HOLD_NEEDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> data_out); // R4

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        !clip_pos && !clip_neg && !fault_now |=> data_out == $past(mod_bit)); // R5

    AST_CLEAR_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_now |=> !hold); // R8

endmodule

bind clip_failsafe_seq cfs_checker u_cfs_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .mod_bit  (mod_bit),
    .clip_pos (clip_pos),
    .clip_neg (clip_neg),
    .fault_now(fault_now),
    .armed    (armed_w),
    .marker   (marker_w),
    .hold     (hold_w),
    .data_out (data_out)
);

// File: tb/clip_failsafe_seq_bench.sv
module clip_failsafe_seq_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mod_bit = 1'b0;
    logic clip_pos = 1'b0;
    logic clip_neg = 1'b0;
    logic supply_lost = 1'b0;
    logic cm_over = 1'b0;
    logic data_out;
    logic clk_out;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        logic  data;
        logic  hold;
        string tag;
    } exp_item_t;

    exp_item_t sb_q[$];

    always #10 clk = ~clk;

    clip_failsafe_seq u_clip_failsafe_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .mod_bit    (mod_bit),
        .clip_pos   (clip_pos),
        .clip_neg   (clip_neg),
        .supply_lost(supply_lost),
        .cm_over    (cm_over),
        .data_out   (data_out),
        .clk_out    (clk_out)
    );

    task automatic check(input logic act, input logic exp, input string tag);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // driver: drive at negedge, push expectation after the edge that captures it
    task automatic step(input logic m, input logic cp, input logic cn,
                        input logic sl, input logic cm,
                        input logic exp_d, input logic exp_h, input string tag);
        exp_item_t it;
        mod_bit = m;
        clip_pos = cp;
        clip_neg = cn;
        supply_lost = sl;
        cm_over = cm;
        @(posedge clk);
        it.data = exp_d;
        it.hold = exp_h;
        it.tag  = tag;
        sb_q.push_back(it);
        @(negedge clk);
    endtask

    // monitor: clk is low here, so clk_out shows the hold state
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb_q.size() > 0) begin
                exp_item_t it;
                it = sb_q.pop_front();
                check(data_out, it.data, {it.tag, " data_out"});
                check(clk_out, it.hold, {it.tag, " clk_out"});
            end
        end
    end

    initial begin
        int cycles = 0;
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: actual %0d cycles expected under 100000", cycles);
                $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
                $finish;
            end
        end
    end

    initial begin
        // R10: reset state
        repeat (3) @(negedge clk);
        #1;
        check(data_out, 1'b0, "R10 reset data_out");
        check(clk_out, 1'b0, "R10 reset clk_out follows clk low");
        @(posedge clk);
        #1;
        check(clk_out, 1'b1, "R10 reset clk_out follows clk high");
        @(negedge clk);
        rst_n = 1'b1;

        // R5: pass-through
        for (int j = 0; j < 8; j++) begin
            step(j % 3 == 0, 0, 0, 0, 0, j % 3 == 0, 0, "R5 normal");
        end

        // R1 / R6: positive clip, mod_bit toggling is ignored
        for (int j = 0; j < 300; j++) begin
            step(j[0], 1, 0, 0, 0, !(j > 0 && j % 128 == 0), 0, "R1 R6 clip high");
        end

        // R2 / R6: polarity change restarts the marker count
        for (int j = 0; j < 140; j++) begin
            step(~j[0], 0, 1, 0, 0, (j > 0 && j % 128 == 0), 0, "R2 R6 clip low");
        end

        for (int j = 0; j < 3; j++) begin
            step(j[0], 0, 0, 0, 0, j[0], 0, "R5 normal again");
        end

        // R3 / R4: supply fault, staged forcing
        for (int j = 0; j < 300; j++) begin
            step(0, 0, 0, 1, 0, j != 0, j >= 257, "R3 R4 supply fault");
        end

        // R8: clear resumes normal output and releases the clock
        for (int j = 0; j < 3; j++) begin
            step(j[0], 0, 0, 0, 0, j[0], 0, "R8 after clear");
        end

        // R7: forcing lands on the cycle where the marker 0 is due
        for (int j = 0; j < 128; j++) begin
            step(0, 1, 0, 0, j == 127, 1, 0, "R7 clip high before fault");
        end
        for (int f = 1; f <= 20; f++) begin
            step(0, 1, 0, 0, 1, 1, 0, "R7 marker suppressed");
        end

        // R8 / R6: clip still present after clear is a fresh entry
        for (int j = 0; j < 130; j++) begin
            step(1, 1, 0, 0, 0, !(j == 128), 0, "R8 R6 clip after clear");
        end

        // R9: single-sample fault pulse
        step(1, 0, 0, 0, 0, 1, 0, "R9 lead-in");
        step(0, 0, 0, 1, 0, 0, 0, "R9 pulse edge");
        step(0, 0, 0, 0, 0, 0, 0, "R9 after pulse");
        step(1, 0, 0, 0, 0, 1, 0, "R9 follow");

        // R7 / R3 / R4: negative clip and supply fault start together
        for (int j = 0; j < 300; j++) begin
            step(1, 0, 1, 1, 0, j != 0, j >= 257, "R7 R3 R4 clip low under fault");
        end

        step(1, 0, 0, 0, 0, 1, 0, "R8 final clear");
        @(negedge clk);
        #2;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule